// File: doc/BRIEF.md
# Serial Transmit Path with Byte Queue

This block is the sending half of a classic asynchronous serial port. The host writes a byte over a simple write strobe. The byte waits in a holding store and then moves into a shift register, which sends it on the `txd` line at one bit per sixteen pulses of an oversampling enable. The holding store works in one of two modes. It can be a deep first-in first-out queue, or a single slot that holds one character, in the way older ports did.

Two status outputs tell the host whether the holding store is drained and whether the whole path, shifter included, has gone quiet. A maskable interrupt asks for more data. In single-slot mode it fires when the slot empties. In queue mode it fires when the fill level falls under a selectable threshold, and again when the queue runs dry. An optional hardware handshake on the active-low clear-to-send input keeps a new character from starting while the far end is not ready.

Top module: `uart_txq_top`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `hold_empty` is 1, `shift_empty` is 1 and `tx_int` is 0.
- R2: A character is sent as a 0 start bit, then the 8 data bits with bit 0 first, then the optional parity bit, then stop bits at 1. Between characters the line rests at 1.
- R3: `par_sel` encodes the parity: 2'b00 and 2'b11 mean no parity bit, 2'b01 means even (the bit is the XOR of the data), and 2'b10 means odd (the bit is the inverted XOR).
- R4: With `two_stop` at 0 the character has one stop bit; with it at 1 it has two.
- R5: Each bit lasts 16 cycles in which `tick16` is high. With `tick16` high every cycle, the start bit is exactly 16 clocks long.
- R6: With `queue_on` at 1, up to DEPTH (64) bytes are held and sent in write order. A write while DEPTH bytes are held is dropped.
- R7: With `queue_on` at 0, the store holds one byte. A write while it is occupied is dropped. `hold_empty` rises when the held byte moves into the shifter.
- R8: `shift_empty` is 1 only when the shifter is idle and the holding store is empty.
- R9: With `cts_auto` at 1, no character starts while `cts_n` is 1. A character already started always finishes.
- R10: In queue mode the interrupt request is set when a transfer to the shifter takes the fill level from the threshold to one below it, and when a transfer leaves the queue empty. `trig_sel` values 0, 1, 2 and 3 pick thresholds of 8, 16, 32 and 56.
- R11: In single-slot mode the request is set when the slot empties into the shifter. Any host write clears the request. `tx_int` is the request ANDed with `int_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the holding store |
| wr_data | input | 8 | Byte to send |
| queue_on | input | 1 | 1 selects the deep queue, 0 the single slot |
| trig_sel | input | 2 | Interrupt threshold select in queue mode |
| par_sel | input | 2 | Parity select |
| two_stop | input | 1 | 1 selects two stop bits |
| tick16 | input | 1 | Oversampling enable, 16 per bit |
| cts_n | input | 1 | Active-low clear to send |
| cts_auto | input | 1 | Enables the clear-to-send hold-off |
| int_en | input | 1 | Transmit interrupt enable |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding store is empty |
| shift_empty | output | 1 | Shifter and holding store are both empty |
| tx_int | output | 1 | Transmit interrupt |

## Verification
The bench decodes the line on its own and sweeps every parity and stop-bit setting over several data patterns, so a design with reversed bit order or an inverted parity sense shows up as a corrupted byte. It fills the queue past capacity while the handshake blocks it, and a design that overwrites on full sends an extra or reordered byte. It drops the handshake in the middle of a character. A design that samples the handshake on every bit truncates that character, and one that ignores it sends the next character early. For each threshold it checks the interrupt just before and just after the crossing, and again when the queue runs empty; an off-by-one in the compare moves the interrupt by a whole character.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    localparam int unsigned FRAME_W = 12;
    localparam int unsigned OSR     = 16;

    typedef enum logic [1:0] {
        PAR_OFF  = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF2 = 2'b11
    } par_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // sent from bit 0 upward
        logic [3:0]         nbits;  // number of bit slots used
    } frame_t;

    function automatic frame_t make_frame(input logic [7:0] d,
                                          input logic [1:0] psel,
                                          input logic       stop2);
        frame_t f;
        logic   has_par;
        logic   pbit;
        has_par = (psel == PAR_EVEN) || (psel == PAR_ODD);
        pbit    = (psel == PAR_ODD) ? ~^d : ^d;
        f.bits  = '1;
        f.bits[0]   = 1'b0;
        f.bits[8:1] = d;
        if (has_par) f.bits[9] = pbit;
        f.nbits = 4'd10 + {3'd0, has_par} + {3'd0, stop2};
        return f;
    endfunction

    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        case (sel)
            2'd0:    return depth / 8;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic [CW-1:0] count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp      <= wp + 1'b1;
            end
            if (pop) rp <= rp + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout = mem[rp];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)) else $error("queue count above depth"); // R6
    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0) else $error("pop from empty queue"); // R6

endmodule

// File: rtl/uart_txq_shifter.sv
module uart_txq_shifter
    import uart_txq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load,
    input  frame_t frame,
    output logic   txd,
    output logic   busy
);
    logic [FRAME_W-1:0]     sr;
    logic [3:0]             nb;
    logic [3:0]             bcnt;
    logic [$clog2(OSR)-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sr   <= '1;
            nb   <= 4'd10;
            bcnt <= '0;
            tcnt <= '0;
        end else if (load && !busy) begin
            busy <= 1'b1;
            sr   <= frame.bits;
            nb   <= frame.nbits;
            bcnt <= '0;
            tcnt <= '0;
        end else if (busy && tick) begin
            if (tcnt == $clog2(OSR)'(OSR - 1)) begin
                tcnt <= '0;
                sr   <= {1'b1, sr[FRAME_W-1:1]};
                if (bcnt == nb - 4'd1) busy <= 1'b0;
                else                   bcnt <= bcnt + 4'd1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign txd = busy ? sr[0] : 1'b1;

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd) else $error("line not marking while idle"); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd) else $error("character not opened by start bit"); // R2
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && $past(busy)) |=> $stable(txd) || !busy) else $error("bit changed without tick"); // R5

endmodule

// File: rtl/uart_txq_top.sv
module uart_txq_top
    import uart_txq_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       queue_on,
    input  logic [1:0] trig_sel,
    input  logic [1:0] par_sel,
    input  logic       two_stop,
    input  logic       tick16,
    input  logic       cts_n,
    input  logic       cts_auto,
    input  logic       int_en,
    output logic       txd,
    output logic       hold_empty,
    output logic       shift_empty,
    output logic       tx_int
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count, cap, trig;
    logic [7:0]    head;
    logic          push, pop, busy, full, held_off, req;
    frame_t        frm;

    assign cap      = queue_on ? CW'(DEPTH) : CW'(1);
    assign trig     = CW'(trig_level(trig_sel, DEPTH));
    assign full     = count >= cap;
    assign push     = wr_en && !full;
    assign held_off = cts_auto && cts_n;
    assign pop      = !busy && (count != '0) && !held_off;
    assign frm      = make_frame(head, par_sel, two_stop);

    uart_txq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .din(wr_data), .dout(head), .count(count)
    );

    uart_txq_shifter u_shift (
        .clk(clk), .rst(rst), .tick(tick16), .load(pop),
        .frame(frm), .txd(txd), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else if (wr_en) begin
            req <= 1'b0;
        end else if (pop) begin
            if (count == CW'(1))                 req <= 1'b1;
            else if (queue_on && count == trig)  req <= 1'b1;
        end
    end

    assign hold_empty  = (count == '0);
    assign shift_empty = hold_empty && !busy;
    assign tx_int      = req && int_en;

    AST_CTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!(cts_auto && cts_n))) else $error("start while clear-to-send off"); // R9
    AST_INT_GATE: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !tx_int) else $error("interrupt not masked"); // R11
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_int) else $error("write left interrupt pending"); // R11
    AST_SHIFT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> hold_empty && txd) else $error("shifter empty while data held"); // R8
    AST_DROP_FULL: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !$past(rst)) |=> $stable(count) || $past(!wr_en)) else $error("write accepted when full"); // R6

endmodule

// File: tb/uart_txq_top_test.sv
module uart_txq_top_test;
    logic       clk = 0;
    logic       rst = 1;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic       queue_on = 1;
    logic [1:0] trig_sel = 0;
    logic [1:0] par_sel = 0;
    logic       two_stop = 0;
    logic       tick16;
    logic       cts_n = 0;
    logic       cts_auto = 0;
    logic       int_en = 0;
    logic       txd, hold_empty, shift_empty, tx_int;

    int checks = 0;
    int fails  = 0;
    int tdiv   = 1;
    int tph    = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    uart_txq_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .queue_on(queue_on), .trig_sel(trig_sel), .par_sel(par_sel),
        .two_stop(two_stop), .tick16(tick16), .cts_n(cts_n),
        .cts_auto(cts_auto), .int_en(int_en), .txd(txd),
        .hold_empty(hold_empty), .shift_empty(shift_empty), .tx_int(tx_int)
    );

    always @(posedge clk) tph <= (tph + 1 >= tdiv) ? 0 : tph + 1;
    assign tick16 = (tph == 0);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] d);
        wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Decode one character from the line; compare to expected byte.
    task automatic recv(input logic [7:0] exp, input string req);
        int per;
        int t;
        logic [7:0] d;
        logic pb;
        per = 16 * tdiv;
        t = 0;
        while (txd !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
        if (t >= 20000) begin chk({req, " start timeout"}, 0, 1); return; end
        cyc(per / 2);
        chk({req, " start"}, txd, 0);
        for (int b = 0; b < 8; b++) begin cyc(per); d[b] = txd; end
        chk({req, " data"}, d, exp);
        if (par_sel == 2'b01 || par_sel == 2'b10) begin
            cyc(per); pb = txd;
            chk({req, " R3 parity"}, pb, (par_sel == 2'b10) ? ~^exp : ^exp);
        end
        cyc(per); chk({req, " R4 stop1"}, txd, 1);
        if (two_stop) begin cyc(per); chk({req, " R4 stop2"}, txd, 1); end
    endtask

    task automatic quiet(input int n, input string req);
        int low = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (!txd) low++; end
        chk(req, low, 0);
    endtask

    initial begin
        cyc(3);
        rst = 0;
        @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 hold_empty", hold_empty, 1);
        chk("R1 shift_empty", shift_empty, 1);
        chk("R1 tx_int", tx_int, 0);

        // R2/R3/R4: all parity and stop settings over several patterns
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                par_sel = p[1:0]; two_stop = s[0];
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] v;
                    v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'(8'h31 + p * 37 + s * 5);
                    put(v);
                    recv(v, "R2");
                    cyc(40);
                end
            end
        end
        par_sel = 0; two_stop = 0;

        // R5: start bit length with tick every cycle
        begin
            int low;
            put(8'h01);
            while (txd) @(negedge clk);
            low = 0;
            while (!txd) begin low++; @(negedge clk); end
            chk("R5 start bit clocks", low, 16);
            cyc(200);
        end
        tdiv = 3;
        put(8'h6C); recv(8'h6C, "R5 slow tick");
        cyc(100);
        tdiv = 1;

        // R6/R9: fill beyond depth while blocked
        cts_auto = 1; cts_n = 1;
        for (int i = 0; i < 66; i++) put(8'(i * 7 + 3));
        quiet(60, "R9 blocked no start");
        chk("R6 hold_empty when filled", hold_empty, 0);
        cts_n = 0;
        for (int i = 0; i < 64; i++) recv(8'(i * 7 + 3), "R6 order");
        quiet(400, "R6 extra writes dropped");
        chk("R8 shift_empty drained", shift_empty, 1);
        chk("R6 hold_empty drained", hold_empty, 1);

        // R7/R8/R11: single-slot mode
        queue_on = 0; cts_n = 1;
        put(8'h5A); put(8'hC3);
        chk("R7 slot held", hold_empty, 0);
        chk("R8 shift_empty with data held", shift_empty, 0);
        cts_n = 0;
        cyc(3);
        cts_n = 1;
        chk("R7 hold_empty after move", hold_empty, 1);
        chk("R8 shift_empty while shifting", shift_empty, 0);
        recv(8'h5A, "R7 held byte");
        quiet(400, "R7 write while occupied dropped");
        chk("R8 shift_empty idle", shift_empty, 1);
        chk("R11 masked", tx_int, 0);
        int_en = 1; @(negedge clk);
        chk("R11 slot empty request", tx_int, 1);
        put(8'h81);
        chk("R11 write clears", tx_int, 0);
        cts_n = 0; cyc(3);
        chk("R11 set on move", tx_int, 1);
        int_en = 0; @(negedge clk);
        chk("R11 gated by enable", tx_int, 0);
        int_en = 1;
        recv(8'h81, "R7 second");
        cyc(200);

        // R9: handshake dropped mid character
        queue_on = 1; cts_n = 0;
        put(8'h96); put(8'h4B);
        fork
            recv(8'h96, "R9 in-progress completes");
            begin cyc(60); cts_n = 1; end
        join
        quiet(400, "R9 next held");
        chk("R9 still queued", hold_empty, 0);
        cts_n = 0;
        recv(8'h4B, "R9 released");
        cyc(200);

        // R10: every threshold
        for (int ts = 0; ts < 4; ts++) begin
            int lvl;
            lvl = (ts == 0) ? 8 : (ts == 1) ? 16 : (ts == 2) ? 32 : 56;
            trig_sel = ts[1:0]; cts_n = 1;
            for (int i = 0; i < lvl + 2; i++) put(8'(i + ts));
            chk("R11 writes cleared", tx_int, 0);
            cts_n = 0;
            recv(8'(0 + ts), "R10 c1");
            recv(8'(1 + ts), "R10 c2");
            chk("R10 above threshold", tx_int, 0);
            recv(8'(2 + ts), "R10 c3");
            chk("R10 crossed threshold", tx_int, 1);
            put(8'hE7);
            chk("R11 write clears in queue mode", tx_int, 0);
            for (int i = 3; i < lvl + 2; i++) recv(8'(i + ts), "R10 drain");
            recv(8'hE7, "R10 last");
            chk("R10 empty request", tx_int, 1);
            cyc(100);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule